// File: doc/BRIEF.md
# Receive Frame Classification Rule Engine

This block decides where a received frame goes. A table of ordered rules is walked one entry per clock. Each entry compares one of several pre-extracted 32-bit frame properties against a stored value. The first rule that completes a match decides the verdict: either the frame is filed to one of 64 receive queues, or it is rejected. If no rule matches, the frame is accepted into queue 0. The engine does not parse frames. It takes the properties as a flat input bus, which must stay stable while a search runs.

Three features let rules work together. A shared mask register is set to all ones at the start of each search, and special rules can reload it part way through. Comparisons can be chained with a Boolean AND. A guard rule can enable or skip a whole bracketed group of rules, and a skipped group includes any mask loads inside it.

A search is started with a one-cycle start pulse. The engine then shows busy, and gives a one-cycle done pulse together with the registered verdict. If the deciding rule asks for an interrupt and files the frame, an event pulse is raised after the end-of-frame strobe that marks the last descriptor write. The rule table is written through a simple port that is locked while a search runs.

Top module: `rxcls_engine`

## Requirements
- R1: A table write (wr_en_i with index, control word, value) is stored only when busy_o is low. A write presented while busy_o is high leaves the table unchanged. The control word layout is: bits [1:0] compare code, bit 2 chain (AND), bit 3 cluster mark, bit 4 reject, bit 5 interrupt request, bits [11:6] queue, bits [14:12] property ID.
- R2: A start pulse sampled while idle raises busy_o on the next edge. When the deciding entry has index k, done_o is high for exactly one cycle, k+1 edges after the start edge, and busy_o falls on that same edge. A start pulse sampled while busy is ignored.
- R3: The mask register is all ones at the beginning of every search, whatever an earlier search loaded into it.
- R4: An entry with property ID 0 is a mask-load rule. When it is evaluated, its value becomes the mask. With compare code 01 it counts as a match and can decide the verdict with its own queue, reject and interrupt fields. Any other compare code counts as a fail, and the search goes on.
- R5: For property ID p≠0, property p (bus slot p, bits [32p+31:32p]) is ANDed with the mask and then compared, unsigned, with the entry value: code 00 equal, 01 greater or equal, 10 not equal, 11 less than.
- R6: The lowest-index entry that completes a match decides the verdict, and the search stops there.
- R7: An entry with AND=1 passes its outcome on to the next entry. A chain matches only if every entry in it matches, and the verdict fields come from the final entry, which has AND=0.
- R8: A chain whose final entry has cluster=1 and AND=1 acts as a guard. If the guard passes, the following entries are evaluated normally up to and including the first entry with cluster=1 and AND=0, and that entry may decide the verdict.
- R9: If the guard fails, every entry up to and including the cluster-ending entry is skipped. Mask-load rules in that range are skipped too.
- R10: If no entry matches, the verdict is accept (reject_o=0) into queue 0 with irq_o=0, and done_o comes N_ENTRY edges after start.
- R11: irq_o is high with the verdict only when the deciding entry has its interrupt bit set and does not reject. In that case, evt_o pulses for one cycle on the edge after the next eof_i strobe. No event follows a verdict with irq_o low.
- R12: reject_o and queue_o give the reject and queue fields of the deciding entry, and they hold until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_ctrl_i | input | CTRL_W (15) | Control word to write |
| wr_val_i | input | PROP_W | Property value to write |
| prop_i | input | N_PROP*PROP_W | Extracted properties, slot p holds property ID p |
| start_i | input | 1 | Start a table search |
| eof_i | input | 1 | Last descriptor of the frame written |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle verdict strobe |
| reject_o | output | 1 | Verdict: frame rejected |
| queue_o | output | QUE_W (6) | Verdict: receive queue |
| irq_o | output | 1 | Verdict: filing rule requests an interrupt |
| evt_o | output | 1 | Interrupt event pulse after end of frame |

## Verification
The bench builds the engine with its default values: 16 entries, 32-bit properties and eight property slots. With only 16 entries, the no-match path walks the entire table, and a write attempted during a search can be tested against a search that lasts the full 16 cycles. Each of the four compare codes is swept against property and value pairs taken from the unsigned boundaries (zero, one, the sign-bit edge and all ones). Chained ranges are tested just inside and just outside both limits. Guarded clusters are tested with the guard passing and failing, with a mask load placed inside the cluster so that a wrongly applied mask changes the verdict.

// File: rtl/rxcls_pkg.sv
package rxcls_pkg;

  localparam int QUE_W = 6;
  localparam int PID_W = 3;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_GE = 2'b01,
    CMP_NE = 2'b10,
    CMP_LT = 2'b11
  } cmp_code_e;

  // control word, LSB first: cmp, andb, cle, rej, irq, queue, pid
  typedef struct packed {
    logic [PID_W-1:0] pid;
    logic [QUE_W-1:0] queue;
    logic             irq;
    logic             rej;
    logic             cle;
    logic             andb;
    logic [1:0]       cmp;
  } rule_ctrl_t;

  localparam int CTRL_W = $bits(rule_ctrl_t);

endpackage

// File: rtl/rxcls_table.sv
module rxcls_table
  import rxcls_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int PROP_W  = 32,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  rule_ctrl_t        wr_ctrl_i,
  input  logic [PROP_W-1:0] wr_val_i,
  input  logic              busy_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output rule_ctrl_t        rd_ctrl_o,
  output logic [PROP_W-1:0] rd_val_o
);

  rule_ctrl_t        ctrl_q [N_ENTRY];
  logic [PROP_W-1:0] val_q  [N_ENTRY];
  logic [N_ENTRY-1:0] ent_we;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    always_comb begin
      ent_we[e] = wr_en_i && !busy_i && (wr_idx_i == IDX_W'(e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[e] <= '0;
        val_q[e]  <= '0;
      end else if (ent_we[e]) begin
        ctrl_q[e] <= wr_ctrl_i;
        val_q[e]  <= wr_val_i;
      end
    end

    // table is frozen during a search
    assert_tbl_hold_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ($stable(ctrl_q[e]) && $stable(val_q[e])));
  end

  always_comb begin
    rd_ctrl_o = ctrl_q[rd_idx_i];
    rd_val_o  = val_q[rd_idx_i];
  end

endmodule

// File: rtl/rxcls_cmp.sv
module rxcls_cmp
  import rxcls_pkg::*;
#(
  parameter int PROP_W = 32
) (
  input  logic [PROP_W-1:0] prop_i,
  input  logic [PROP_W-1:0] mask_i,
  input  logic [PROP_W-1:0] value_i,
  input  logic [1:0]        cmp_i,
  output logic              hit_o
);

  logic [PROP_W-1:0] masked;

  always_comb begin
    masked = prop_i & mask_i;
    unique case (cmp_code_e'(cmp_i))
      CMP_EQ:  hit_o = (masked == value_i);
      CMP_GE:  hit_o = (masked >= value_i);
      CMP_NE:  hit_o = (masked != value_i);
      default: hit_o = (masked <  value_i);
    endcase
  end

endmodule

// File: rtl/rxcls_seq.sv
module rxcls_seq
  import rxcls_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int PROP_W  = 32,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  rule_ctrl_t        ctrl_i,
  input  logic [PROP_W-1:0] val_i,
  input  logic              hit_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PROP_W-1:0] mask_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rej_o,
  output logic [QUE_W-1:0]  que_o,
  output logic              irq_o
);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PROP_W-1:0] mask_q, mask_d;
  logic              chain_q, chain_d;
  logic              skip_q, skip_d;
  logic              done_q, done_d;
  logic              rej_q, rej_d;
  logic [QUE_W-1:0]  que_q, que_d;
  logic              irq_q, irq_d;

  logic is_mask, eff_hit, comb_ok, last, cl_end, match, finish;

  always_comb begin
    is_mask = (ctrl_i.pid == '0);
    eff_hit = is_mask ? (ctrl_i.cmp == CMP_GE) : hit_i;
    comb_ok = chain_q && eff_hit;
    last    = (idx_q == IDX_W'(N_ENTRY - 1));
    cl_end  = ctrl_i.cle && !ctrl_i.andb;

    busy_d  = busy_q;
    idx_d   = idx_q;
    mask_d  = mask_q;
    chain_d = chain_q;
    skip_d  = skip_q;
    done_d  = 1'b0;
    rej_d   = rej_q;
    que_d   = que_q;
    irq_d   = irq_q;
    match   = 1'b0;
    finish  = 1'b0;

    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        mask_d  = '1;
        chain_d = 1'b1;
        skip_d  = 1'b0;
      end
    end else begin
      if (skip_q) begin
        if (cl_end) skip_d = 1'b0;
      end else begin
        if (is_mask) mask_d = val_i;
        if (ctrl_i.andb) begin
          if (ctrl_i.cle) begin
            chain_d = 1'b1;
            skip_d  = !comb_ok;
          end else begin
            chain_d = comb_ok;
          end
        end else begin
          chain_d = 1'b1;
          match   = comb_ok;
        end
      end

      if (match) begin
        finish = 1'b1;
        rej_d  = ctrl_i.rej;
        que_d  = ctrl_i.queue;
        irq_d  = ctrl_i.irq && !ctrl_i.rej;
      end else if (last) begin
        finish = 1'b1;
        rej_d  = 1'b0;
        que_d  = '0;
        irq_d  = 1'b0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end

      if (finish) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      mask_q  <= '1;
      chain_q <= 1'b1;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      que_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      mask_q  <= mask_d;
      chain_q <= chain_d;
      skip_q  <= skip_d;
      done_q  <= done_d;
      rej_q   <= rej_d;
      que_q   <= que_d;
      irq_q   <= irq_d;
    end
  end

  assign idx_o  = idx_q;
  assign mask_o = mask_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rej_o  = rej_q;
  assign que_o  = que_q;
  assign irq_o  = irq_q;

  assert_done_pulse_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_mask_init_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (mask_q == '1 && idx_q == '0));
  assert_skip_mask_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && skip_q) |=> $stable(mask_q));
  assert_verdict_hold_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(que_q) && $stable(rej_q)) or $rose(busy_q) or busy_q);

endmodule

// File: rtl/rxcls_engine.sv
module rxcls_engine
  import rxcls_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int PROP_W  = 32,
  localparam int IDX_W  = $clog2(N_ENTRY),
  localparam int N_PROP = 2 ** PID_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [CTRL_W-1:0]        wr_ctrl_i,
  input  logic [PROP_W-1:0]        wr_val_i,
  input  logic [N_PROP*PROP_W-1:0] prop_i,
  input  logic                     start_i,
  input  logic                     eof_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     reject_o,
  output logic [QUE_W-1:0]         queue_o,
  output logic                     irq_o,
  output logic                     evt_o
);

  rule_ctrl_t        rd_ctrl;
  logic [PROP_W-1:0] rd_val;
  logic [IDX_W-1:0]  rd_idx;
  logic [PROP_W-1:0] mask;
  logic [PROP_W-1:0] sel_prop;
  logic              hit;
  logic              busy, done, rej, irq;
  logic [QUE_W-1:0]  que;

  rxcls_table #(.N_ENTRY(N_ENTRY), .PROP_W(PROP_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_ctrl_i (rule_ctrl_t'(wr_ctrl_i)),
    .wr_val_i  (wr_val_i),
    .busy_i    (busy),
    .rd_idx_i  (rd_idx),
    .rd_ctrl_o (rd_ctrl),
    .rd_val_o  (rd_val)
  );

  always_comb begin
    sel_prop = prop_i[int'(rd_ctrl.pid)*PROP_W +: PROP_W];
  end

  rxcls_cmp #(.PROP_W(PROP_W)) u_cmp (
    .prop_i  (sel_prop),
    .mask_i  (mask),
    .value_i (rd_val),
    .cmp_i   (rd_ctrl.cmp),
    .hit_o   (hit)
  );

  rxcls_seq #(.N_ENTRY(N_ENTRY), .PROP_W(PROP_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ctrl_i  (rd_ctrl),
    .val_i   (rd_val),
    .hit_i   (hit),
    .idx_o   (rd_idx),
    .mask_o  (mask),
    .busy_o  (busy),
    .done_o  (done),
    .rej_o   (rej),
    .que_o   (que),
    .irq_o   (irq)
  );

  // interrupt event: armed by a filing verdict, fired by end of frame
  logic pend_q, pend_d, evt_q, evt_d;

  always_comb begin
    pend_d = pend_q;
    if (done && irq)  pend_d = 1'b1;
    else if (eof_i)   pend_d = 1'b0;
    evt_d = eof_i && pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign busy_o   = busy;
  assign done_o   = done;
  assign reject_o = rej;
  assign queue_o  = que;
  assign irq_o    = irq;
  assign evt_o    = evt_q;

  assert_evt_after_eof_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(eof_i));
  assert_irq_not_reject_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(irq_o && reject_o));

endmodule

// File: tb/test_rxcls_engine.sv
`timescale 1ns/1ps
module test_rxcls_engine;
  import rxcls_pkg::*;

  localparam int NE = 16;
  localparam int PW = 32;
  localparam int IW = $clog2(NE);
  localparam int NP = 2 ** PID_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [IW-1:0]     wr_idx;
  logic [CTRL_W-1:0] wr_ctrl;
  logic [PW-1:0]     wr_val;
  logic [NP*PW-1:0]  prop_bus;
  logic              start, eof;
  logic              busy, done, reject, irq, evt;
  logic [QUE_W-1:0]  queue;
  logic [PW-1:0]     props [NP];

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < NP; i++) begin : g_pb
    assign prop_bus[i*PW +: PW] = props[i];
  end

  rxcls_engine i_rxcls_engine (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_ctrl_i(wr_ctrl), .wr_val_i(wr_val), .prop_i(prop_bus),
    .start_i(start), .eof_i(eof), .busy_o(busy), .done_o(done),
    .reject_o(reject), .queue_o(queue), .irq_o(irq), .evt_o(evt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CTRL_W-1:0] mk(input int pid, input int cmp, input bit andb,
                                           input bit cle, input bit rej, input bit irqb,
                                           input int q);
    rule_ctrl_t c;
    c.pid = PID_W'(pid); c.queue = QUE_W'(q); c.irq = irqb; c.rej = rej;
    c.cle = cle; c.andb = andb; c.cmp = 2'(cmp);
    return c;
  endfunction

  function automatic bit cmpf(input int c, input logic [PW-1:0] p, input logic [PW-1:0] v);
    case (c)
      0: return p == v;
      1: return p >= v;
      2: return p != v;
      default: return p < v;
    endcase
  endfunction

  localparam logic [CTRL_W-1:0] FILL = 15'h0003; // pid 0, code 11: loads all ones, fails

  task automatic wr(input int idx, input logic [CTRL_W-1:0] c, input logic [PW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_ctrl = c; wr_val = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill();
    for (int e = 0; e < NE; e++) wr(e, FILL, '1);
  endtask

  task automatic search(output int lat);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic expect_v(input string tag, input int k, input int q, input bit rj, input bit ir);
    int lat;
    search(lat);
    chk(lat == k + 1, {tag, " latency"}, lat, k + 1);
    chk(queue == QUE_W'(q), {tag, " queue"}, queue, q);
    chk(reject == rj, {tag, " reject"}, reject, rj);
    chk(irq == ir, {tag, " irq"}, irq, ir);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] pv [5];
    int lat;
    int extra;
    pv[0] = 32'h0; pv[1] = 32'h1; pv[2] = 32'h7FFF_FFFF; pv[3] = 32'h8000_0000; pv[4] = '1;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_ctrl = '0; wr_val = '0;
    start = 1'b0; eof = 1'b0;
    for (int i = 0; i < NP; i++) props[i] = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!busy && !done && !evt, "R2 reset outputs", {busy, done, evt}, 0);
    rst_n = 1'b1;

    // R10 no match over the full table
    fill();
    expect_v("R10 no match", NE - 1, 0, 1'b0, 1'b0);

    // R5 R6 sweep of compare codes over unsigned boundaries; entry1 default (R4)
    wr(1, mk(0, 1, 0, 0, 0, 0, 9), '1);
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++) begin
          props[1] = pv[a];
          wr(0, mk(1, c, 0, 0, 0, 0, 5), pv[b]);
          if (cmpf(c, pv[a], pv[b])) expect_v("R5 R6 cmp hit", 0, 5, 1'b0, 1'b0);
          else                       expect_v("R5 R4 cmp miss default", 1, 9, 1'b0, 1'b0);
        end

    // R3 R4 R5 mask load then masked compare; mask reset on every search
    fill();
    props[2] = 32'hABCD_1234;
    wr(0, mk(2, 0, 0, 0, 0, 0, 3), 32'h0000_1234);
    wr(1, mk(0, 3, 0, 0, 0, 0, 0), 32'h0000_FFFF);
    wr(2, mk(2, 0, 0, 0, 0, 0, 7), 32'h0000_1234);
    expect_v("R4 R5 masked match", 2, 7, 1'b0, 1'b0);
    expect_v("R3 mask reset second search", 2, 7, 1'b0, 1'b0);

    // R4 R12 mask-load match with reject
    wr(0, mk(0, 1, 0, 0, 1, 0, 17), '1);
    expect_v("R4 R12 reject verdict", 0, 17, 1'b1, 1'b0);

    // R7 chained range 10 <= p < 20
    fill();
    wr(0, mk(1, 1, 1, 0, 1, 0, 11), 32'd10);
    wr(1, mk(1, 3, 0, 0, 0, 0, 12), 32'd20);
    wr(2, mk(0, 1, 0, 0, 0, 0, 1), '1);
    for (int p = 5; p <= 25; p += 1) begin
      props[1] = p;
      if (p >= 10 && p < 20) expect_v("R7 chain in range", 1, 12, 1'b0, 1'b0);
      else                   expect_v("R7 chain out of range", 2, 1, 1'b0, 1'b0);
    end

    // R8 R9 guarded cluster containing a mask load
    fill();
    wr(0, mk(1, 0, 1, 1, 0, 0, 0), 32'h0000_00AA);
    wr(1, mk(0, 3, 0, 0, 0, 0, 0), 32'h0000_00FF);
    wr(2, mk(2, 0, 0, 1, 0, 0, 20), 32'h0000_0034);
    wr(3, mk(2, 0, 0, 0, 0, 0, 21), 32'h0000_0034);
    wr(4, mk(0, 1, 0, 0, 0, 0, 2), '1);
    props[1] = 32'hAA; props[2] = 32'h1234;
    expect_v("R8 guard pass cluster end files", 2, 20, 1'b0, 1'b0);
    props[1] = 32'hAB;
    expect_v("R9 guard fail mask load skipped", 4, 2, 1'b0, 1'b0);
    props[2] = 32'h34;
    expect_v("R9 guard fail skips cluster end", 3, 21, 1'b0, 1'b0);

    // R1 write during a search is ignored
    fill();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wr_en = 1'b1; wr_idx = '0; wr_ctrl = mk(0, 1, 0, 0, 0, 0, 33); wr_val = '1;
    @(negedge clk); wr_en = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == NE, "R1 search during write latency", lat, NE);
    expect_v("R1 busy write ignored", NE - 1, 0, 1'b0, 1'b0);
    wr(0, mk(0, 1, 0, 0, 0, 0, 33), '1);
    expect_v("R1 idle write stored", 0, 33, 1'b0, 1'b0);

    // R2 start while busy ignored, single done
    fill();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R2 busy after start", busy, 1);
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 4;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == NE, "R2 restart ignored latency", lat, NE);
    chk(!busy, "R2 busy falls with done", busy, 0);
    @(negedge clk);
    chk(!done, "R2 done one cycle", done, 0);
    extra = 0;
    repeat (20) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R2 no second done", extra, 0);

    // R11 interrupt event after end of frame
    wr(0, mk(0, 1, 0, 0, 0, 1, 4), '1);
    expect_v("R11 filing irq", 0, 4, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(!evt, "R11 no event before eof", evt, 0);
    eof = 1'b1; @(negedge clk); eof = 1'b0;
    chk(evt, "R11 event after eof", evt, 1);
    @(negedge clk);
    chk(!evt, "R11 event one cycle", evt, 0);
    wr(0, mk(0, 1, 0, 0, 1, 1, 4), '1);
    expect_v("R11 R12 reject suppresses irq", 0, 4, 1'b1, 1'b0);
    eof = 1'b1; @(negedge clk); eof = 1'b0;
    chk(!evt, "R11 no event after reject", evt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule